// File: doc/BRIEF.md
# CPU Trace Capture Buffer

This block keeps a rolling record of recent CPU bus activity so that a small monitor processor can inspect it afterwards. Each cycle in which the capture strobe is high, one 64-bit trace entry is stored in a single write. The entry holds the full 32-bit access address, the byte seen on the read data bus and the internal sequencer state byte. The capture side has its own clock and reset. It keeps a 4-bit write pointer that moves through 16 entries in a circle, so the newest 16 captures are always kept.

The monitor processor reads the same storage one byte at a time, on a second clock, through a 4 KB window in its 16-bit address space. Only the low seven address bits choose the byte, so the 128-byte image repeats across the window. A freeze input stops capture so that software can read a stable snapshot. The write pointer is an output, which lets software find the oldest entry.

Top module: `trace_capture_buffer`

## Requirements
- R1: The entry layout in byte lanes is as follows. Lanes 0 to 3 hold the access address, least significant byte in lane 0. Lane 4 holds the read-bus byte, lane 5 holds the sequencer state, and lanes 6 and 7 read as zero.
- R2: A capture strobe seen at a capture clock edge stores the whole entry, in that one cycle, at the slot named by `wr_index`.
- R3: `wr_index` advances by one after each accepted capture and wraps from 15 to 0. Otherwise it holds its value.
- R4: While `cap_freeze` is high, a strobe neither writes storage nor moves `wr_index`.
- R5: While the resets are low, `wr_index` is 0 and `mon_rdata` is 0.
- R6: Within the window, `mon_addr[6:3]` selects the entry and `mon_addr[2:0]` selects the lane. Bits [11:7] are ignored, so the image repeats every 128 bytes.
- R7: `mon_hit` is high exactly when `mon_addr[15:12]` is 4'h7. An address outside the window gives `mon_rdata` = 0 after the next monitor clock edge.
- R8: `mon_rdata` is registered. It shows the byte for the address that was present at the previous monitor clock edge.
- R9: If a read and a capture address the same entry at the same edge, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Capture-side clock |
| cap_rst_n | input | 1 | Capture-side reset, active low |
| cap_strobe | input | 1 | Store one trace entry this cycle |
| cap_freeze | input | 1 | Blocks capture while high |
| seq_state | input | 8 | Internal sequencer state byte |
| bus_rdata | input | 8 | Byte currently on the read data bus |
| access_addr | input | 32 | Address being accessed |
| wr_index | output | 4 | Slot the next capture will fill |
| mon_clk | input | 1 | Monitor-side clock |
| mon_rst_n | input | 1 | Monitor-side reset, active low |
| mon_addr | input | 16 | Monitor CPU address |
| mon_hit | output | 1 | Address lies in the trace window |
| mon_rdata | output | 8 | Registered read byte |

## Verification
The hardest case to reach is a read and a capture that hit the same slot at the same edge. To create it, the stimulus first fills all 16 slots so that the pointer wraps back to slot 0, whose contents are known. It then raises the strobe and presents the address of slot 0 in the same cycle, so that the old byte and then the new byte can be observed. Two further cases are handled separately. Aliasing is exercised with addresses whose bits [11:7] are nonzero. Freeze is checked by reading back the slot the pointer names after a blocked strobe.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
   localparam int DEF_ADDR_W  = 32;
   localparam int DEF_FIELD_W = 8;
   localparam int DEF_ENTRY_W = 64;
   localparam int DEF_IDX_W   = 4;
   localparam int DEF_RD_W    = 8;
   localparam int DEF_CPU_AW  = 16;
   localparam int DEF_WIN_W   = 12;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/tcb_entry_pack.sv
module tcb_entry_pack #(
   parameter int ADDR_W  = 32,
   parameter int FIELD_W = 8,
   parameter int ENTRY_W = 64
) (
   input  logic [FIELD_W-1:0] seq_state,
   input  logic [FIELD_W-1:0] bus_rdata,
   input  logic [ADDR_W-1:0]  access_addr,
   output logic [ENTRY_W-1:0] entry
);
   localparam int USED_W = ADDR_W + 2 * FIELD_W;
   localparam int PAD_W  = ENTRY_W - USED_W;

   if (USED_W > ENTRY_W) begin : g_bad_width
      $error("entry width too small for packed fields");
   end

   if (PAD_W > 0) begin : g_pad
      assign entry = {{PAD_W{1'b0}}, seq_state, bus_rdata, access_addr};
   end else begin : g_nopad
      assign entry = {seq_state, bus_rdata, access_addr};
   end
endmodule

// File: rtl/tcb_wr_index.sv
module tcb_wr_index #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic             freeze,
   output logic             we,
   output logic [IDX_W-1:0] idx
);
   assign we = strobe & ~freeze;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (we) begin
         idx <= idx + 1'b1;
      end
   end
endmodule

// File: rtl/tcb_window_decode.sv
module tcb_window_decode #(
   parameter int             CPU_AW   = 16,
   parameter int             WIN_W    = 12,
   parameter int             RA_W     = 7,
   parameter logic [15:0]    WIN_BASE = 16'h7000
) (
   input  logic [CPU_AW-1:0] cpu_addr,
   output logic              hit,
   output logic [RA_W-1:0]   offset
);
   localparam int TAG_W = CPU_AW - WIN_W;
   localparam logic [TAG_W-1:0] TAG = WIN_BASE[CPU_AW-1:WIN_W];

   if (RA_W > WIN_W) begin : g_bad_window
      $error("window smaller than storage image");
   end
   if (WIN_BASE[WIN_W-1:0] != '0) begin : g_bad_base
      $error("window base not aligned to window size");
   end

   assign hit    = (cpu_addr[CPU_AW-1:WIN_W] == TAG);
   assign offset = cpu_addr[RA_W-1:0];
endmodule

// File: rtl/tcb_dpram.sv
module tcb_dpram #(
   parameter int ENTRY_W = 64,
   parameter int IDX_W   = 4,
   parameter int RD_W    = 8
) (
   input  logic               wclk,
   input  logic               we,
   input  logic [IDX_W-1:0]   widx,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic               rclk,
   input  logic               rrst_n,
   input  logic               rsel,
   input  logic [IDX_W+$clog2(ENTRY_W/RD_W)-1:0] raddr,
   output logic [RD_W-1:0]    rdata
);
   localparam int DEPTH     = 1 << IDX_W;
   localparam int LANES     = ENTRY_W / RD_W;
   localparam int LANE_BITS = $clog2(LANES);

   if (ENTRY_W % RD_W != 0) begin : g_bad_lanes
      $error("entry width not a multiple of read width");
   end

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [IDX_W-1:0]     r_entry;
   logic [LANE_BITS-1:0] r_lane;
   logic [RD_W-1:0]      lane_q [LANES];

   assign r_entry = raddr[IDX_W+LANE_BITS-1:LANE_BITS];
   assign r_lane  = raddr[LANE_BITS-1:0];

   always_ff @(posedge wclk) begin
      if (we) begin
         mem[widx] <= wdata;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_q[g] = mem[r_entry][g*RD_W +: RD_W];
   end

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rdata <= '0;
      end else if (rsel) begin
         rdata <= lane_q[r_lane];
      end else begin
         rdata <= '0;
      end
   end
endmodule

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer
   import tcb_pkg::*;
#(
   parameter int          ADDR_W   = DEF_ADDR_W,
   parameter int          FIELD_W  = DEF_FIELD_W,
   parameter int          ENTRY_W  = DEF_ENTRY_W,
   parameter int          IDX_W    = DEF_IDX_W,
   parameter int          RD_W     = DEF_RD_W,
   parameter int          CPU_AW   = DEF_CPU_AW,
   parameter int          WIN_W    = DEF_WIN_W,
   parameter logic [15:0] WIN_BASE = 16'h7000
) (
   input  logic               cap_clk,
   input  logic               cap_rst_n,
   input  logic               cap_strobe,
   input  logic               cap_freeze,
   input  logic [FIELD_W-1:0] seq_state,
   input  logic [FIELD_W-1:0] bus_rdata,
   input  logic [ADDR_W-1:0]  access_addr,
   output logic [IDX_W-1:0]   wr_index,
   input  logic               mon_clk,
   input  logic               mon_rst_n,
   input  logic [CPU_AW-1:0]  mon_addr,
   output logic               mon_hit,
   output logic [RD_W-1:0]    mon_rdata
);
   localparam int LANES     = ENTRY_W / RD_W;
   localparam int LANE_BITS = $clog2(LANES);
   localparam int RA_W      = IDX_W + LANE_BITS;

   if (!is_pow2(LANES)) begin : g_bad_lane_count
      $error("lane count must be a power of two");
   end

   logic [ENTRY_W-1:0] entry;
   logic               we;
   logic [RA_W-1:0]    offset;

   tcb_entry_pack #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .ENTRY_W(ENTRY_W)) i_pack (
      .seq_state  (seq_state),
      .bus_rdata  (bus_rdata),
      .access_addr(access_addr),
      .entry      (entry)
   );

   tcb_wr_index #(.IDX_W(IDX_W)) i_index (
      .clk   (cap_clk),
      .rst_n (cap_rst_n),
      .strobe(cap_strobe),
      .freeze(cap_freeze),
      .we    (we),
      .idx   (wr_index)
   );

   tcb_window_decode #(.CPU_AW(CPU_AW), .WIN_W(WIN_W), .RA_W(RA_W), .WIN_BASE(WIN_BASE)) i_decode (
      .cpu_addr(mon_addr),
      .hit     (mon_hit),
      .offset  (offset)
   );

   tcb_dpram #(.ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .RD_W(RD_W)) i_ram (
      .wclk  (cap_clk),
      .we    (we),
      .widx  (wr_index),
      .wdata (entry),
      .rclk  (mon_clk),
      .rrst_n(mon_rst_n),
      .rsel  (mon_hit),
      .raddr (offset),
      .rdata (mon_rdata)
   );
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
   parameter int ADDR_W  = 32,
   parameter int FIELD_W = 8,
   parameter int ENTRY_W = 64,
   parameter int IDX_W   = 4,
   parameter int RD_W    = 8,
   parameter int CPU_AW  = 16
) (
   input logic              cap_clk,
   input logic              cap_rst_n,
   input logic              cap_strobe,
   input logic              cap_freeze,
   input logic [IDX_W-1:0]  wr_index,
   input logic              mon_clk,
   input logic              mon_rst_n,
   input logic [CPU_AW-1:0] mon_addr,
   input logic              mon_hit,
   input logic [RD_W-1:0]   mon_rdata
);
   localparam int LANE_BITS = $clog2(ENTRY_W / RD_W);
   localparam int USED_LANES = (ADDR_W + 2 * FIELD_W) / RD_W;

   logic [LANE_BITS-1:0] lane;
   assign lane = mon_addr[LANE_BITS-1:0];

   AST_IDX_STEP: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
      (cap_strobe && !cap_freeze) |=> (wr_index == IDX_W'($past(wr_index) + 1'b1))); // R3
   AST_IDX_WRAP: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
      (cap_strobe && !cap_freeze && (wr_index == '1)) |=> (wr_index == '0)); // R3
   AST_FREEZE_HOLD: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
      cap_freeze |=> $stable(wr_index)); // R4
   AST_MISS_ZERO: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
      !mon_hit |=> (mon_rdata == '0)); // R7
   AST_PAD_ZERO: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
      (mon_hit && (int'(lane) >= USED_LANES)) |=> (mon_rdata == '0)); // R1
endmodule

bind trace_capture_buffer tcb_checker #(
   .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .ENTRY_W(ENTRY_W),
   .IDX_W(IDX_W), .RD_W(RD_W), .CPU_AW(CPU_AW)
) i_tcb_checker (
   .cap_clk   (cap_clk),
   .cap_rst_n (cap_rst_n),
   .cap_strobe(cap_strobe),
   .cap_freeze(cap_freeze),
   .wr_index  (wr_index),
   .mon_clk   (mon_clk),
   .mon_rst_n (mon_rst_n),
   .mon_addr  (mon_addr),
   .mon_hit   (mon_hit),
   .mon_rdata (mon_rdata)
);

// File: tb/test_trace_capture_buffer.sv
module test_trace_capture_buffer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_strobe = 1'b0;
   logic        cap_freeze = 1'b0;
   logic [7:0]  seq_state = '0;
   logic [7:0]  bus_rdata = '0;
   logic [31:0] access_addr = '0;
   logic [3:0]  wr_index;
   logic [15:0] mon_addr = 16'h0000;
   logic        mon_hit;
   logic [7:0]  mon_rdata;

   int  errors = 0;
   int  checks = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   trace_capture_buffer i_trace_capture_buffer (
      .cap_clk(clk), .cap_rst_n(rst_n), .cap_strobe(cap_strobe), .cap_freeze(cap_freeze),
      .seq_state(seq_state), .bus_rdata(bus_rdata), .access_addr(access_addr),
      .wr_index(wr_index), .mon_clk(clk), .mon_rst_n(rst_n), .mon_addr(mon_addr),
      .mon_hit(mon_hit), .mon_rdata(mon_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Behavioural reference: byte image of the buffer and a pointer.
   logic [7:0] ref_mem [128];
   int         ref_idx = 0;
   logic [7:0] ref_rd = '0;

   initial begin
      for (int i = 0; i < 128; i++) ref_mem[i] = 'x;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         ref_idx = 0;
         ref_rd  = '0;
      end else begin
         if (mon_addr[15:12] == 4'h7) ref_rd = ref_mem[mon_addr[6:0]];
         else ref_rd = '0;
         if (cap_strobe && !cap_freeze) begin
            ref_mem[ref_idx*8+0] = access_addr[7:0];
            ref_mem[ref_idx*8+1] = access_addr[15:8];
            ref_mem[ref_idx*8+2] = access_addr[23:16];
            ref_mem[ref_idx*8+3] = access_addr[31:24];
            ref_mem[ref_idx*8+4] = bus_rdata;
            ref_mem[ref_idx*8+5] = seq_state;
            ref_mem[ref_idx*8+6] = 8'h00;
            ref_mem[ref_idx*8+7] = 8'h00;
            ref_idx = (ref_idx + 1) % 16;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 pointer vs model", {28'd0, wr_index}, ref_idx);
         chk("R7 hit vs model", {31'd0, mon_hit}, {31'd0, mon_addr[15:12] == 4'h7});
         if (!$isunknown(ref_rd)) chk("R8 read data vs model", {24'd0, mon_rdata}, {24'd0, ref_rd});
      end
   end

   task automatic capture(input logic [7:0] st, input logic [7:0] bd, input logic [31:0] ad,
                          input logic frz);
      @(negedge clk);
      seq_state = st; bus_rdata = bd; access_addr = ad;
      cap_freeze = frz; cap_strobe = 1'b1;
      @(negedge clk);
      cap_strobe = 1'b0; cap_freeze = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] b);
      @(negedge clk);
      mon_addr = a;
      @(negedge clk);
      b = mon_rdata;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      mon_addr = 16'h7005;
      repeat (3) @(negedge clk);
      chk("R5 reset pointer", {28'd0, wr_index}, 0);
      chk("R5 reset read data", {24'd0, mon_rdata}, 0);
      rst_n = 1'b1;

      capture(8'hA5, 8'h3C, 32'h1234_5678, 1'b0);
      chk("R2 pointer after first capture", {28'd0, wr_index}, 1);
      rd(16'h7000, b); chk("R1 lane0 address low", {24'd0, b}, 32'h78);
      rd(16'h7003, b); chk("R1 lane3 address high", {24'd0, b}, 32'h12);
      rd(16'h7004, b); chk("R1 lane4 bus byte", {24'd0, b}, 32'h3C);
      rd(16'h7005, b); chk("R1 lane5 state byte", {24'd0, b}, 32'hA5);
      rd(16'h7006, b); chk("R1 lane6 pad", {24'd0, b}, 32'h00);
      rd(16'h7007, b); chk("R1 lane7 pad", {24'd0, b}, 32'h00);

      for (int i = 1; i < 16; i++) begin
         capture(8'(i), 8'(i + 16), 32'hABCD_0000 + 32'(i), 1'b0);
      end
      chk("R3 pointer wrapped", {28'd0, wr_index}, 0);

      rd(16'h7048, b); chk("R6 entry9 lane0", {24'd0, b}, 32'h09);
      rd(16'h7FC8, b); chk("R6 alias of entry9 lane0", {24'd0, b}, 32'h09);
      rd(16'h704C, b); chk("R6 entry9 lane4", {24'd0, b}, 32'h19);
      rd(16'h7A7A, b); chk("R6 alias entry15 lane2", {24'd0, b}, 32'hCD);

      rd(16'h6048, b); chk("R7 below window", {24'd0, b}, 32'h00);
      chk("R7 hit low outside", {31'd0, mon_hit}, 0);
      rd(16'h8048, b); chk("R7 above window", {24'd0, b}, 32'h00);

      // R9: write slot 0 while reading slot 0 at the same edge
      @(negedge clk);
      seq_state = 8'h11; bus_rdata = 8'h22; access_addr = 32'hCAFE_F00D;
      cap_strobe = 1'b1; mon_addr = 16'h7000;
      @(negedge clk);
      cap_strobe = 1'b0;
      chk("R9 old contents on collision", {24'd0, mon_rdata}, 32'h78);
      @(negedge clk);
      chk("R9 new contents afterwards", {24'd0, mon_rdata}, 32'h0D);

      capture(8'hEE, 8'hEE, 32'hEEEE_EEEE, 1'b1);
      chk("R4 pointer held under freeze", {28'd0, wr_index}, 1);
      rd(16'h7008, b); chk("R4 slot unchanged under freeze", {24'd0, b}, 32'h01);
      rd(16'h700D, b); chk("R4 state byte unchanged", {24'd0, b}, 32'h01);

      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule